// File: doc/BRIEF.md
# Interleaved Quadrature Downconverter with Coefficient Table

This block takes one stream of 8-bit unsigned converter samples carrying four receiver channels in turn, and turns each sample into a signed in-phase and quadrature pair. The signal of every channel sits at a quarter of that channel's own sample rate. Because of this, the mixing coefficients for one channel repeat every four of its samples. One small table of pre-combined coefficients can therefore hold, in a single entry per position, the carrier, that channel's gain and phase correction, and the steering phase for a beam. A single multiply per output then does downconversion, calibration and steering together.

A controller fills the table at run time through a data, address and write-strobe port. It rewrites the table whenever the beam or the calibration changes. An internal sequence counter advances on every accepted sample and addresses the table. The in-phase coefficient comes from the counter position. The quadrature coefficient comes from the same sequence read one same-channel sample earlier, which is four interleaved slots back. Each result leaves the block two clocks after its sample, tagged with the channel slot it belongs to. A parameter widens the interleave to two beams per channel: the table then doubles to 32 words, and the source repeats each sample once per beam.

Top module: `qtab_ddc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `res_valid` is 0, `res_i` and `res_q` are 0 and `res_slot` is 0. All table entries read as 0 until they are written.
- R2: Each input sample s is centred before multiplying as the signed value s - 128, so 0 maps to -128, 128 to 0 and 255 to +127.
- R3: The sequence counter starts at 0 after reset and advances by one, modulo 16, only on a cycle with `smp_valid` high. `res_slot` equals the counter value used for that sample, modulo 4.
- R4: `res_i` equals (s - 128) times the signed 9-bit table entry at the counter position k of that sample.
- R5: `res_q` equals (s - 128) times the signed 9-bit table entry at position (k - 4) modulo 16.
- R6: A result appears two clocks after its sample: `res_valid` is high exactly two cycles after each cycle with `smp_valid` high. On a cycle with `res_valid` low, `res_i` and `res_q` keep their previous values.
- R7: A table write with `cf_we` high changes the entry from the next clock on. A sample accepted in the same cycle as a write to the entry it reads uses the old value.
- R8: Products are 17-bit signed and exact over the full ranges, from (-128)(255) = -32640 up to (-128)(-256) = +32768, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four times the per-channel sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present on `smp_data` this cycle |
| smp_data | input | 8 | Offset-binary converter sample |
| cf_wdata | input | 9 | Signed coefficient to store |
| cf_waddr | input | 4 | Table entry to write |
| cf_we | input | 1 | Table write strobe |
| res_valid | output | 1 | Result present on `res_i` / `res_q` |
| res_slot | output | 2 | Channel slot of the current result |
| res_i | output | 17 | Signed in-phase product |
| res_q | output | 17 | Signed quadrature product |

## Verification
A table of all ones with a sweep of samples isolates the centring step, because each product then equals the centred sample. A table of distinct values per entry, driven with an unbroken stream, shows whether the counter order and the four-slot backward offset for the quadrature read are right: swapping the offset direction or reusing the in-phase address gives different values. Gapped valid patterns separate a counter that runs on every clock from one that runs on valid samples only, and they also expose any result that moves while idle. Rewriting the entry being read in the same cycle, and full-scale samples against the extreme coefficients, expose read-during-write ordering and any truncation of the product.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int SMP_W     = 8;
  localparam int COEF_W    = 9;
  localparam int CHANNELS  = 4;
  localparam int PERIOD    = 4;
  localparam int SMP_ZERO  = 128;
  localparam int CTR_W     = SMP_W + 1;
  localparam int PROD_W    = CTR_W + COEF_W - 1;

  typedef logic signed [CTR_W-1:0]  centred_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [PROD_W-1:0] prod_t;
endpackage

// File: rtl/ddc_seq_counter.sv
module ddc_seq_counter #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx;
    if (adv) begin
      if (idx == LAST) idx_d = '0;
      else             idx_d = idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= idx_d;
  end
endmodule

// File: rtl/ddc_coef_table.sv
module ddc_coef_table #(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int COEF_W = 9,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [COEF_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [COEF_W-1:0] cos_word,
  output logic [COEF_W-1:0] sin_word
);
  localparam logic [IDX_W-1:0] LAG = IDX_W'(LANES);

  logic [COEF_W-1:0] entry [DEPTH];
  logic [IDX_W-1:0]  sin_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry[g] <= '0;
      else if (hit) entry[g] <= wdata;
    end
  end

  always_comb begin
    sin_idx  = rd_idx - LAG;
    cos_word = entry[rd_idx];
    sin_word = entry[sin_idx];
  end
endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer
  import ddc_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SMP_W-1:0]    in_sample,
  input  logic [LANE_W-1:0]   in_lane,
  input  logic [COEF_W-1:0]   cos_word,
  input  logic [COEF_W-1:0]   sin_word,
  output logic                out_valid,
  output logic [LANE_W-1:0]   out_lane,
  output prod_t               out_i,
  output prod_t               out_q
);
  localparam logic [CTR_W-1:0] ZERO_LVL = CTR_W'(SMP_ZERO);

  logic              s1_valid;
  logic [LANE_W-1:0] s1_lane;
  centred_t          s1_smp;
  coef_t             s1_cos;
  coef_t             s1_sin;
  centred_t          smp_d;
  prod_t             prod_i_d;
  prod_t             prod_q_d;

  always_comb begin
    smp_d = centred_t'(CTR_W'(in_sample) - ZERO_LVL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_lane  <= '0;
      s1_smp   <= '0;
      s1_cos   <= '0;
      s1_sin   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_lane <= in_lane;
        s1_smp  <= smp_d;
        s1_cos  <= coef_t'(cos_word);
        s1_sin  <= coef_t'(sin_word);
      end
    end
  end

  always_comb begin
    prod_i_d = PROD_W'(s1_smp) * PROD_W'(s1_cos);
    prod_q_d = PROD_W'(s1_smp) * PROD_W'(s1_sin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lane  <= '0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_lane <= s1_lane;
        out_i    <= prod_i_d;
        out_q    <= prod_q_d;
      end
    end
  end
endmodule

// File: rtl/qtab_ddc.sv
module qtab_ddc
  import ddc_pkg::*;
#(
  parameter int BEAMS  = 1,
  parameter int LANES  = CHANNELS * BEAMS,
  parameter int DEPTH  = LANES * PERIOD,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic [SMP_W-1:0]         smp_data,
  input  logic [COEF_W-1:0]        cf_wdata,
  input  logic [IDX_W-1:0]         cf_waddr,
  input  logic                     cf_we,
  output logic                     res_valid,
  output logic [LANE_W-1:0]        res_slot,
  output logic signed [PROD_W-1:0] res_i,
  output logic signed [PROD_W-1:0] res_q
);
  logic [IDX_W-1:0]  seq_idx;
  logic [COEF_W-1:0] cos_word;
  logic [COEF_W-1:0] sin_word;
  logic [LANE_W-1:0] cur_lane;

  assign cur_lane = seq_idx[LANE_W-1:0];

  ddc_seq_counter #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (smp_valid),
    .idx   (seq_idx)
  );

  ddc_coef_table #(.DEPTH(DEPTH), .LANES(LANES), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cf_we),
    .waddr    (cf_waddr),
    .wdata    (cf_wdata),
    .rd_idx   (seq_idx),
    .cos_word (cos_word),
    .sin_word (sin_word)
  );

  ddc_mixer #(.LANE_W(LANE_W)) u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (smp_valid),
    .in_sample (smp_data),
    .in_lane   (cur_lane),
    .cos_word  (cos_word),
    .sin_word  (sin_word),
    .out_valid (res_valid),
    .out_lane  (res_slot),
    .out_i     (res_i),
    .out_q     (res_q)
  );
endmodule

// File: rtl/qtab_ddc_checker.sv
module qtab_ddc_checker #(
  parameter int SMP_W  = 8,
  parameter int PROD_W = 17,
  parameter int LANE_W = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smp_valid,
  input logic [SMP_W-1:0]         smp_data,
  input logic                     res_valid,
  input logic [LANE_W-1:0]        res_slot,
  input logic signed [PROD_W-1:0] res_i,
  input logic signed [PROD_W-1:0] res_q
);
  logic              seen_res;
  logic [LANE_W-1:0] prev_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_res  <= 1'b0;
      prev_slot <= '0;
    end else if (res_valid) begin
      seen_res  <= 1'b1;
      prev_slot <= res_slot;
    end
  end

  // R6: result follows its sample by two clocks
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ##2 res_valid);
  p_no_phantom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> ##2 !res_valid);
  // R6: outputs stay put while idle
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_i) && $stable(res_q)));
  // R3: slots step one at a time
  p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && seen_res) |-> (res_slot == LANE_W'(prev_slot + 1'b1)));
  // R2: the mid-scale code centres to zero
  p_mid_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_data == SMP_W'(128)) |-> ##2 (res_i == 0 && res_q == 0));
  // R8: products stay inside the exact range
  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_i >= -32640 && res_i <= 32768 && res_q >= -32640 && res_q <= 32768));
endmodule

bind qtab_ddc qtab_ddc_checker #(
  .SMP_W(ddc_pkg::SMP_W), .PROD_W(ddc_pkg::PROD_W), .LANE_W(LANE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_data  (smp_data),
  .res_valid (res_valid),
  .res_slot  (res_slot),
  .res_i     (res_i),
  .res_q     (res_q)
);

// File: tb/sim_qtab_ddc.sv
module sim_qtab_ddc;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int LANES      = 4;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [7:0]  smp_data;
  logic [8:0]  cf_wdata;
  logic [3:0]  cf_waddr;
  logic        cf_we;
  logic        res_valid;
  logic [1:0]  res_slot;
  logic signed [16:0] res_i;
  logic signed [16:0] res_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  qtab_ddc u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cf_wdata(cf_wdata), .cf_waddr(cf_waddr), .cf_we(cf_we),
    .res_valid(res_valid), .res_slot(res_slot), .res_i(res_i), .res_q(res_q)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  int    ref_tab [DEPTH];
  int    ref_idx  = 0;
  bit    p0_v = 0, p1_v = 0;
  int    p0_i = 0, p0_q = 0, p0_s = 0, p1_i = 0, p1_q = 0, p1_s = 0;
  int    last_i = 0, last_q = 0;
  string cur_tag = "";

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare();
    check(res_valid == p1_v, {"R6 valid ", cur_tag}, int'(res_valid), int'(p1_v));
    if (p1_v) begin
      check(int'(res_slot) == p1_s, {"R3 slot ", cur_tag}, int'(res_slot), p1_s);
      check(int'(res_i) == p1_i, {"R4 in-phase ", cur_tag}, int'(res_i), p1_i);
      check(int'(res_q) == p1_q, {"R5 quadrature ", cur_tag}, int'(res_q), p1_q);
      last_i = p1_i;
      last_q = p1_q;
    end else begin
      check(int'(res_i) == last_i, {"R6 hold i ", cur_tag}, int'(res_i), last_i);
      check(int'(res_q) == last_q, {"R6 hold q ", cur_tag}, int'(res_q), last_q);
    end
  endtask

  // one clock: check outputs, drive inputs, advance the model
  task automatic step(bit v, int s, bit we, int wa, int wd);
    int c;
    @(negedge clk);
    compare();
    smp_valid = v;
    smp_data  = 8'(s);
    cf_we     = we;
    cf_waddr  = 4'(wa);
    cf_wdata  = 9'(wd);
    c = s - 128;
    p1_v = p0_v; p1_i = p0_i; p1_q = p0_q; p1_s = p0_s;
    p0_v = v;
    if (v) begin
      p0_i = c * ref_tab[ref_idx];
      p0_q = c * ref_tab[(ref_idx - LANES + DEPTH) % DEPTH];
      p0_s = ref_idx % LANES;
      ref_idx = (ref_idx + 1) % DEPTH;
    end
    if (we) ref_tab[wa] = wd;
  endtask

  task automatic load(int k, int val);
    step(1'b0, 0, 1'b1, k, val);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) ref_tab[k] = 0;
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
    cf_we = 1'b0; cf_waddr = '0; cf_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(res_valid == 1'b0, "R1 valid in reset", int'(res_valid), 0);
    check(res_i == 0, "R1 i in reset", int'(res_i), 0);
    check(res_q == 0, "R1 q in reset", int'(res_q), 0);
    check(res_slot == 0, "R1 slot in reset", int'(res_slot), 0);
    rst_n = 1'b1;

    // R1: unwritten table reads zero
    cur_tag = "R1 empty table";
    for (int n = 0; n < 4; n++) step(1'b1, 200 + n, 1'b0, 0, 0);

    // R2: unit table shows the centred sample directly
    cur_tag = "R2 centring";
    for (int k = 0; k < DEPTH; k++) load(k, 1);
    step(1'b1, 0, 0, 0, 0);
    step(1'b1, 1, 0, 0, 0);
    step(1'b1, 127, 0, 0, 0);
    step(1'b1, 128, 0, 0, 0);
    step(1'b1, 129, 0, 0, 0);
    step(1'b1, 255, 0, 0, 0);

    // R4 R5: distinct coefficients, unbroken stream
    cur_tag = "R4 R5 stream";
    for (int k = 0; k < DEPTH; k++) load(k, ((k * 37 + 11) % 511) - 255);
    for (int n = 0; n < 48; n++) step(1'b1, (n * 29 + 7) % 256, 0, 0, 0);

    // R3 R6: gapped valid pattern
    cur_tag = "R3 R6 gaps";
    for (int n = 0; n < 40; n++) step((n % 3) != 0, (n * 53 + 3) % 256, 0, 0, 0);

    // R7: rewrite the entry being read in the same cycle
    cur_tag = "R7 read during write";
    for (int n = 0; n < 20; n++) step(1'b1, (n * 71 + 5) % 256, 1'b1, ref_idx, -(n * 13) + 100);

    // R8: full-scale samples against extreme coefficients
    cur_tag = "R8 extremes";
    for (int k = 0; k < DEPTH; k++) load(k, (k % 2 == 0) ? -256 : 255);
    for (int n = 0; n < 16; n++) step(1'b1, ((n / 2) % 2 == 0) ? 0 : 255, 0, 0, 0);

    cur_tag = "drain";
    for (int n = 0; n < 4; n++) step(1'b0, 0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule